// File: doc/BRIEF.md
# Calendar Clock Transaction Sequencer

This block performs complete calendar transactions on an external serial clock chip. It does not move bits on the serial wire itself. Instead it asks a lower nibble-register master to do one 4-bit register read or write at a time, and it decides what those accesses are. A host gives it one of three commands: fetch the current time, load a new time, or run a start-up validity check. The block then drives the chip-enable line, makes each access in a fixed order, and ends with a single done or error pulse.

Time values cross the command side as packed BCD bytes: seconds, minutes, hours, day of month, month and two-digit year, plus a 4-bit weekday. Inside the chip each byte is held in two registers, one for the units digit and one for the tens digit.

Before touching any time register, every transaction makes one or more access attempts. An attempt loads the control register, reads it back and looks at its busy flag. While the chip reports busy, the block drops chip enable for a guard interval and tries again, up to a bounded number of attempts. The start-up check first reads the oscillator-stop flag. If that flag is set, it disables the periodic interrupt, starts an adjust cycle and waits for it to finish, then loads a default date.

Top module: `rtcseq_top`

## Requirements
- R1: After reset, `ce`, `reg_req`, `done` and `err` are low and every `rd_*` output is zero.
- R2: Every access attempt first writes 0x4 to address 0xE, then reads address 0xE, all with `ce` high. Register data is only accessed after a control read that returns bit 0 clear.
- R3: When the control read returns bit 0 set, `ce` goes low for GAP_CYC cycles and the attempt repeats. Once MAX_TRIES attempts have all read busy, `err` pulses and no time register is accessed.
- R4: A read command fetches addresses 0,1,2,3,4,5,8,9,0xA,0xB,0xC,0xD and then 6. Each pair gives units (bits 3:0) and tens (bits 7:4) of seconds, minutes, hours, day, month and year, and address 6 gives the 4-bit weekday.
- R5: A set command writes the same addresses in the same order. Units come from bits 3:0 of the field and tens from bits 7:4, and the weekday is written last. The set values are captured when the command is accepted.
- R6: A check command reads address 0xE. If bit 1 of that value is clear, the operation ends with `done` and makes no write.
- R7: If that bit 1 is set, the check writes 0x0 to address 7 and 0x7 to address 0xE. It then reads 0xE until bit 0 is clear, with at most MAX_POLL reads. Finally it runs a set sequence with day 0x01, month 0x01 and all other fields zero.
- R8: `reg_req` is only high while `ce` is high. After each operation, `ce` stays low for at least GAP_CYC cycles before `done` or `err` is raised.
- R9: `done` and `err` are one-cycle pulses and are never high together.
- R10: The `rd_*` outputs change only during a read command and stay stable from its `done` onward.
- R11: A command is accepted only when the block is idle. `cmd_op` is 0 read, 1 set, 2 check, and 3 is ignored. A command that arrives while an operation runs causes no access.
- R12: While `reg_req` is high and `reg_ack` is low, `reg_wr`, `reg_addr` and `reg_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 read, 1 set, 2 check, 3 none |
| set_sec | input | 8 | BCD seconds to load |
| set_min | input | 8 | BCD minutes to load |
| set_hour | input | 8 | BCD hours to load |
| set_day | input | 8 | BCD day to load |
| set_mon | input | 8 | BCD month to load |
| set_year | input | 8 | BCD year to load |
| set_wday | input | 4 | Weekday to load |
| rd_sec | output | 8 | BCD seconds read |
| rd_min | output | 8 | BCD minutes read |
| rd_hour | output | 8 | BCD hours read |
| rd_day | output | 8 | BCD day read |
| rd_mon | output | 8 | BCD month read |
| rd_year | output | 8 | BCD year read |
| rd_wday | output | 4 | Weekday read |
| done | output | 1 | Operation complete pulse |
| err | output | 1 | Busy timeout pulse |
| ce | output | 1 | Chip enable to the clock chip |
| reg_req | output | 1 | Register access request to the master |
| reg_wr | output | 1 | 1 write, 0 read |
| reg_addr | output | 4 | Register address |
| reg_wdata | output | 4 | Nibble to write |
| reg_ack | input | 1 | Access complete pulse from the master |
| reg_rdata | input | 4 | Nibble read, valid with `reg_ack` |

## Verification
The bench models the chip as a nibble register file whose busy flag stays set for a chosen number of control reads. It logs every access and compares the log with an expected list built from the requirements.

- **Address order and nibble placement.** A design that swaps units and tens, or skips the gap at addresses 6 and 7, shows up as a log mismatch or a wrong `rd_*` byte.
- **Exhausted busy retry.** A retry counter that is off by one makes a different number of attempt pairs, or lets a data access slip through before `err`.
- **Check flow with a long adjust wait.** The bench holds busy for more than MAX_POLL reads, so a design that does not cap the poll keeps reading.
- **Guard intervals and commands that must be ignored.** Every rise of `ce` and every end pulse is timed against GAP_CYC. A command sent mid-operation must add no access, and a later set must not disturb the held read result.

// File: rtl/rtcseq_pkg.sv
package rtcseq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_SET   = 2'd1,
    OP_CHECK = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
    logic [3:0] wday;
  } cal_t;

  localparam logic [3:0] ADDR_CTRL  = 4'hE;
  localparam logic [3:0] ADDR_IRQIV = 4'h7;
  localparam logic [3:0] CTRL_RUN   = 4'h4;
  localparam logic [3:0] CTRL_ADJ   = 4'h7;
  localparam logic [3:0] LAST_STEP  = 4'd12;

  localparam cal_t CAL_DEFAULT = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   day: 8'h01, mon: 8'h01, year: 8'h00,
                                   wday: 4'h0};

  // nibble of a calendar record that belongs to transfer step s
  function automatic logic [3:0] cal_nib(input cal_t c, input logic [3:0] s);
    case (s)
      4'd0:  return c.sec[3:0];
      4'd1:  return c.sec[7:4];
      4'd2:  return c.min[3:0];
      4'd3:  return c.min[7:4];
      4'd4:  return c.hour[3:0];
      4'd5:  return c.hour[7:4];
      4'd6:  return c.day[3:0];
      4'd7:  return c.day[7:4];
      4'd8:  return c.mon[3:0];
      4'd9:  return c.mon[7:4];
      4'd10: return c.year[3:0];
      4'd11: return c.year[7:4];
      default: return c.wday;
    endcase
  endfunction

  // calendar record with the nibble of step s replaced
  function automatic cal_t cal_put(input cal_t c, input logic [3:0] s,
                                   input logic [3:0] n);
    cal_t r;
    r = c;
    case (s)
      4'd0:  r.sec[3:0]  = n;
      4'd1:  r.sec[7:4]  = n;
      4'd2:  r.min[3:0]  = n;
      4'd3:  r.min[7:4]  = n;
      4'd4:  r.hour[3:0] = n;
      4'd5:  r.hour[7:4] = n;
      4'd6:  r.day[3:0]  = n;
      4'd7:  r.day[7:4]  = n;
      4'd8:  r.mon[3:0]  = n;
      4'd9:  r.mon[7:4]  = n;
      4'd10: r.year[3:0] = n;
      4'd11: r.year[7:4] = n;
      default: r.wday    = n;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtcseq_cnt.sv
module rtcseq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (clr)      cnt_n = '0;
    else if (inc) cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || inc) cnt <= cnt_n;
  end
endmodule

// File: rtl/rtcseq_map.sv
module rtcseq_map
  import rtcseq_pkg::*;
(
  input  logic [3:0] step,
  input  cal_t       cal,
  output logic [3:0] addr,
  output logic [3:0] nib
);
  // steps 0..5 sit at their own address, 6..11 skip weekday and interval
  always_comb begin
    if (step == LAST_STEP)  addr = 4'h6;
    else if (step >= 4'd6)  addr = step + 4'd2;
    else                    addr = step;
    nib = cal_nib(cal, step);
  end
endmodule

// File: rtl/rtcseq_top.sv
module rtcseq_top
  import rtcseq_pkg::*;
#(
  parameter int GAP_CYC   = 140,
  parameter int MAX_TRIES = 100,
  parameter int MAX_POLL  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] set_sec,
  input  logic [7:0] set_min,
  input  logic [7:0] set_hour,
  input  logic [7:0] set_day,
  input  logic [7:0] set_mon,
  input  logic [7:0] set_year,
  input  logic [3:0] set_wday,
  output logic [7:0] rd_sec,
  output logic [7:0] rd_min,
  output logic [7:0] rd_hour,
  output logic [7:0] rd_day,
  output logic [7:0] rd_mon,
  output logic [7:0] rd_year,
  output logic [3:0] rd_wday,
  output logic       done,
  output logic       err,
  output logic       ce,
  output logic       reg_req,
  output logic       reg_wr,
  output logic [3:0] reg_addr,
  output logic [3:0] reg_wdata,
  input  logic       reg_ack,
  input  logic [3:0] reg_rdata
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam int PW = $clog2(MAX_POLL + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_AW, S_AR, S_XF, S_CR, S_CWI, S_CWC, S_CP, S_GAP
  } st_e;

  // reset: asserted asynchronously, released on the clock
  logic rs_a, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a  <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs_a  <= 1'b1;
      rst_s <= rs_a;
    end
  end

  st_e        state_q, state_n;
  logic [3:0] step_q, step_n;
  logic       opwr_q, opwr_n;
  logic       gend_q, gend_n;
  cal_t       cal_q, cal_n;
  cal_t       rd_q, rd_n;
  logic       done_n, err_n;
  logic       acc, try_inc, poll_inc, gap_last;
  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] try_cnt;
  logic [PW-1:0] poll_cnt;
  logic [3:0] map_addr, map_nib;

  rtcseq_cnt #(.W(GW)) u_gap (.clk(clk), .rst_n(rst_s),
    .clr(state_q != S_GAP), .inc(state_q == S_GAP), .cnt(gap_cnt));
  rtcseq_cnt #(.W(TW)) u_try (.clk(clk), .rst_n(rst_s),
    .clr(acc), .inc(try_inc), .cnt(try_cnt));
  rtcseq_cnt #(.W(PW)) u_poll (.clk(clk), .rst_n(rst_s),
    .clr(acc), .inc(poll_inc), .cnt(poll_cnt));
  rtcseq_map u_map (.step(step_q), .cal(cal_q), .addr(map_addr), .nib(map_nib));

  assign gap_last = (gap_cnt == GW'(GAP_CYC - 1));

  always_comb begin
    state_n = state_q; step_n = step_q; opwr_n = opwr_q; gend_n = gend_q;
    cal_n = cal_q; rd_n = rd_q; done_n = 1'b0; err_n = 1'b0;
    acc = 1'b0; try_inc = 1'b0; poll_inc = 1'b0;
    case (state_q)
      S_IDLE: if (cmd_valid && op_e'(cmd_op) != OP_NONE) begin
        acc    = 1'b1;
        opwr_n = (op_e'(cmd_op) != OP_READ);
        if (op_e'(cmd_op) == OP_CHECK) begin
          cal_n   = CAL_DEFAULT;
          state_n = S_CR;
        end else begin
          cal_n   = '{sec: set_sec, min: set_min, hour: set_hour, day: set_day,
                      mon: set_mon, year: set_year, wday: set_wday};
          state_n = S_AW;
        end
      end
      S_AW: if (reg_ack) state_n = S_AR;
      S_AR: if (reg_ack) begin
        if (!reg_rdata[0]) begin
          step_n  = '0;
          state_n = S_XF;
        end else begin
          try_inc = 1'b1;
          gend_n  = 1'b0;
          state_n = S_GAP;
        end
      end
      S_XF: if (reg_ack) begin
        if (!opwr_q) rd_n = cal_put(rd_q, step_q, reg_rdata);
        if (step_q == LAST_STEP) begin
          gend_n  = 1'b1;
          state_n = S_GAP;
        end else begin
          step_n = step_q + 4'd1;
        end
      end
      S_CR: if (reg_ack) begin
        if (reg_rdata[1]) state_n = S_CWI;
        else begin
          gend_n  = 1'b1;
          state_n = S_GAP;
        end
      end
      S_CWI: if (reg_ack) state_n = S_CWC;
      S_CWC: if (reg_ack) state_n = S_CP;
      S_CP: if (reg_ack) begin
        poll_inc = 1'b1;
        if (!reg_rdata[0] || poll_cnt == PW'(MAX_POLL - 1)) state_n = S_AW;
      end
      S_GAP: if (gap_last) begin
        if (gend_q) begin
          done_n  = 1'b1;
          state_n = S_IDLE;
        end else if (try_cnt == TW'(MAX_TRIES)) begin
          err_n   = 1'b1;
          state_n = S_IDLE;
        end else begin
          state_n = S_AW;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      opwr_q  <= 1'b0;
      gend_q  <= 1'b0;
      cal_q   <= '0;
      rd_q    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_n;
      step_q  <= step_n;
      opwr_q  <= opwr_n;
      gend_q  <= gend_n;
      done    <= done_n;
      err     <= err_n;
      if (acc) cal_q <= cal_n;
      if (state_q == S_XF) rd_q <= rd_n;
    end
  end

  always_comb begin
    ce        = (state_q != S_IDLE) && (state_q != S_GAP);
    reg_req   = ce;
    reg_wr    = 1'b0;
    reg_addr  = ADDR_CTRL;
    reg_wdata = 4'h0;
    case (state_q)
      S_AW:  begin reg_wr = 1'b1; reg_wdata = CTRL_RUN; end
      S_XF:  begin reg_wr = opwr_q; reg_addr = map_addr; reg_wdata = map_nib; end
      S_CWI: begin reg_wr = 1'b1; reg_addr = ADDR_IRQIV; end
      S_CWC: begin reg_wr = 1'b1; reg_wdata = CTRL_ADJ; end
      default: ;
    endcase
  end

  assign rd_sec  = rd_q.sec;
  assign rd_min  = rd_q.min;
  assign rd_hour = rd_q.hour;
  assign rd_day  = rd_q.day;
  assign rd_mon  = rd_q.mon;
  assign rd_year = rd_q.year;
  assign rd_wday = rd_q.wday;

  AST_REQ_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_s)
    reg_req |-> ce); // R8
  AST_END_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_s)
    (done || err) |-> (!ce && $past(!ce))); // R8
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_s)
    (done || err) |=> !(done || err)); // R9
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_s)
    !(done && err)); // R9
  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_s)
    try_cnt <= TW'(MAX_TRIES)); // R3
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_s)
    poll_cnt <= PW'(MAX_POLL)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == S_IDLE) |=> $stable(rd_q)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) &&
      $stable(reg_wr) && $stable(reg_wdata))); // R12
endmodule

// File: tb/sim_rtcseq_top.sv
`timescale 1ns/1ps
module sim_rtcseq_top;
  localparam int GAP = 140;
  localparam int MAXT = 100;
  localparam int MAXP = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic [7:0] s_sec = 0, s_min = 0, s_hour = 0, s_day = 0, s_mon = 0, s_year = 0;
  logic [3:0] s_wday = 0;
  logic [7:0] rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year;
  logic [3:0] rd_wday;
  logic done, err, ce, reg_req, reg_wr;
  logic [3:0] reg_addr, reg_wdata;
  logic reg_ack = 1'b0;
  logic [3:0] reg_rdata = 4'h0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtcseq_top #(.GAP_CYC(GAP), .MAX_TRIES(MAXT), .MAX_POLL(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .set_sec(s_sec), .set_min(s_min), .set_hour(s_hour), .set_day(s_day),
    .set_mon(s_mon), .set_year(s_year), .set_wday(s_wday),
    .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_day(rd_day),
    .rd_mon(rd_mon), .rd_year(rd_year), .rd_wday(rd_wday),
    .done(done), .err(err), .ce(ce), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata));

  // ---------------- chip model ----------------
  logic [3:0] creg [16];
  int busy_left = 0;
  bit ostop = 1'b0;
  logic [8:0] log_q [$];
  logic [8:0] exp_q [$];
  int wcnt = 0;

  initial begin
    for (int i = 0; i < 16; i++) creg[i] = 4'h0;
    forever begin
      @(negedge clk);
      if (reg_ack) begin
        reg_ack = 1'b0;
        wcnt = 0;
      end else if (reg_req && ce) begin
        wcnt++;
        if (wcnt == 2) begin
          if (reg_wr) begin
            creg[reg_addr] = reg_wdata;
            log_q.push_back({1'b1, reg_addr, reg_wdata});
          end else begin
            if (reg_addr == 4'hE) begin
              reg_rdata = {creg[14][3:2], ostop, busy_left > 0};
              if (busy_left > 0) busy_left--;
            end else begin
              reg_rdata = creg[reg_addr];
            end
            log_q.push_back({1'b0, reg_addr, 4'h0});
          end
          reg_ack = 1'b1;
        end
      end
    end
  end

  // ---------------- per-clock monitor ----------------
  bit ce_prev = 1'b0;
  bit end_prev = 1'b0;
  int lowrun = 100000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_req && !ce) chk(1'b0, "R8 req without ce", 1, 0);
      if (ce && !ce_prev) chk(lowrun >= GAP, "R8 ce low interval", lowrun, GAP);
      if (done || err) chk(lowrun >= GAP, "R8 gap before end pulse", lowrun, GAP);
      if (done && err) chk(1'b0, "R9 done with err", 1, 0);
      if (end_prev && (done || err)) chk(1'b0, "R9 pulse width", 2, 1);
      if (ce) lowrun = 0; else lowrun++;
      ce_prev = ce;
      end_prev = done || err;
    end
  end

  // ---------------- expected model ----------------
  logic [3:0] ordr [13] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8, 4'h9,
                            4'hA, 4'hB, 4'hC, 4'hD, 4'h6};
  logic [7:0] e_fld [6];
  logic [3:0] e_wday;

  function automatic logic [3:0] bnib(input int s);
    logic [7:0] b;
    if (s == 12) return e_wday;
    b = e_fld[s / 2];
    return (s % 2) ? b[7:4] : b[3:0];
  endfunction

  task automatic exp_attempts(input int nbusy);
    int n;
    n = (nbusy < MAXT) ? nbusy + 1 : MAXT;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b1, 4'hE, 4'h4});
      exp_q.push_back({1'b0, 4'hE, 4'h0});
    end
  endtask

  task automatic exp_data(input bit wr);
    for (int s = 0; s < 13; s++)
      exp_q.push_back({wr, ordr[s], wr ? bnib(s) : 4'h0});
  endtask

  task automatic cmp_log(input string req);
    bit ok;
    int bad;
    ok = (log_q.size() == exp_q.size());
    bad = -1;
    if (ok)
      for (int i = 0; i < log_q.size(); i++)
        if (log_q[i] !== exp_q[i] && bad < 0) begin
          bad = i;
          ok = 1'b0;
        end
    if (bad >= 0) chk(1'b0, req, log_q[bad], exp_q[bad]);
    else chk(ok, req, log_q.size(), exp_q.size());
    log_q.delete();
    exp_q.delete();
  endtask

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    cmd_op = op;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = 2'd3;
  endtask

  task automatic wait_end(input bit want_err, input string req);
    int n;
    n = 0;
    while (!(done || err) && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(want_err ? (err && !done) : (done && !err), req, {done, err},
        want_err ? 1 : 2);
    @(negedge clk);
  endtask

  task automatic chk_rd(input string req);
    chk({rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year, rd_wday} ===
        {e_fld[0], e_fld[1], e_fld[2], e_fld[3], e_fld[4], e_fld[5], e_wday},
        req, {rd_sec, rd_min, rd_hour}, {e_fld[0], e_fld[1], e_fld[2]});
  endtask

  task automatic load_chip();
    for (int s = 0; s < 13; s++) creg[ordr[s]] = bnib(s);
  endtask

  task automatic drive_set();
    s_sec = e_fld[0]; s_min = e_fld[1]; s_hour = e_fld[2];
    s_day = e_fld[3]; s_mon = e_fld[4]; s_year = e_fld[5]; s_wday = e_wday;
  endtask

  task automatic chk_chip(input string req);
    bit ok;
    ok = 1'b1;
    for (int s = 0; s < 13; s++) if (creg[ordr[s]] !== bnib(s)) ok = 1'b0;
    chk(ok, req, {creg[13], creg[12]}, e_fld[5]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- scenarios ----------------
  logic [7:0] keep [6];
  logic [3:0] keep_w;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!ce && !reg_req && !done && !err, "R1 control outputs", {ce, reg_req, done, err}, 0);
    chk({rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year, rd_wday} == '0,
        "R1 rd outputs", rd_sec, 0);

    // R4 + R2: read, chip idle
    e_fld = '{8'h59, 8'h47, 8'h23, 8'h31, 8'h12, 8'h99}; e_wday = 4'h6;
    load_chip();
    issue(2'd0);
    wait_end(1'b0, "R4 read done");
    exp_attempts(0); exp_data(1'b0);
    cmp_log("R2 R4 read access order");
    chk_rd("R4 read result fields");

    // R3: read with busy for three attempts
    e_fld = '{8'h07, 8'h30, 8'h09, 8'h05, 8'h10, 8'h24}; e_wday = 4'h2;
    load_chip();
    busy_left = 3;
    issue(2'd0);
    wait_end(1'b0, "R3 retried read done");
    exp_attempts(3); exp_data(1'b0);
    cmp_log("R3 retry access log");
    chk_rd("R3 R4 read after retries");

    // R10: held result stable, not touched by a set
    keep = e_fld; keep_w = e_wday;
    repeat (50) @(negedge clk);
    chk_rd("R10 result held after done");
    e_fld = '{8'h15, 8'h02, 8'h18, 8'h28, 8'h02, 8'h25}; e_wday = 4'h3;
    drive_set();
    issue(2'd1);
    s_sec = 8'hFF; s_year = 8'hFF; // R5 values captured at accept
    wait_end(1'b0, "R5 set done");
    exp_attempts(0); exp_data(1'b1);
    cmp_log("R5 set write order and nibbles");
    chk_chip("R5 chip contents after set");
    e_fld = keep; e_wday = keep_w;
    chk_rd("R10 result unchanged by set");

    // R6: check, oscillator ok
    ostop = 1'b0;
    issue(2'd2);
    wait_end(1'b0, "R6 check done");
    exp_q.push_back({1'b0, 4'hE, 4'h0});
    cmp_log("R6 check with stop flag clear");

    // R7: check, oscillator stopped, short adjust wait
    ostop = 1'b1;
    busy_left = 3;
    issue(2'd2);
    wait_end(1'b0, "R7 check restore done");
    e_fld = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00}; e_wday = 4'h0;
    exp_q.push_back({1'b0, 4'hE, 4'h0});
    exp_q.push_back({1'b1, 4'h7, 4'h0});
    exp_q.push_back({1'b1, 4'hE, 4'h7});
    for (int i = 0; i < 3; i++) exp_q.push_back({1'b0, 4'hE, 4'h0});
    exp_attempts(0); exp_data(1'b1);
    cmp_log("R7 check restore sequence");
    chk_chip("R7 default date written");

    // R7: poll capped at MAX_POLL reads
    busy_left = MAXP + 1;
    issue(2'd2);
    wait_end(1'b0, "R7 capped poll done");
    exp_q.push_back({1'b0, 4'hE, 4'h0});
    exp_q.push_back({1'b1, 4'h7, 4'h0});
    exp_q.push_back({1'b1, 4'hE, 4'h7});
    for (int i = 0; i < MAXP; i++) exp_q.push_back({1'b0, 4'hE, 4'h0});
    exp_attempts(0); exp_data(1'b1);
    cmp_log("R7 poll read cap");
    ostop = 1'b0;

    // R3: timeout
    busy_left = 100000;
    issue(2'd0);
    wait_end(1'b1, "R3 timeout error pulse");
    exp_attempts(MAXT);
    cmp_log("R3 attempts before timeout, no data access");
    busy_left = 0;
    e_fld = keep; e_wday = keep_w;
    chk_rd("R10 result unchanged by failed read");

    // R11: commands during an operation, and op code 3
    e_fld = '{8'h11, 8'h22, 8'h13, 8'h14, 8'h05, 8'h16}; e_wday = 4'h1;
    load_chip();
    issue(2'd0);
    repeat (10) @(negedge clk);
    issue(2'd1);
    issue(2'd2);
    wait_end(1'b0, "R11 read done with stray commands");
    exp_attempts(0); exp_data(1'b0);
    cmp_log("R11 stray commands ignored");
    chk_rd("R11 read result");
    issue(2'd3);
    repeat (400) @(negedge clk);
    chk(log_q.size() == 0 && !ce, "R11 no access after op 3 or stray", log_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule